// File: doc/BRIEF.md
# Four-Channel Pulse Qualifier with Interrupt

The block takes four raw sensor pulse lines and removes short interference with a slow sampling strobe. Each line first passes a two-stage synchronizer. A channel then counts sample strobes for as long as its line stays high. When the count reaches 16 the channel is qualified. The counter then freezes until the line drops or a clear arrives. A dropped line zeroes its counter at once, so glitches cannot add up across separate bursts.

Each channel keeps a sticky flag that records that it was qualified. Several pulses that overlap in time therefore stay visible to the processor. An interrupt line rises once every qualified channel has returned to idle, that is, when the OR of the four qualified bits falls. The processor reads the flags and then pulses the active-low clear. The clear zeroes counters and flags at the next clock edge and drops the interrupt at once, without waiting for a clock edge.

Each channel is a small state machine: `CH_IDLE` (count zero), `CH_COUNT` (counting strobes) and `CH_HELD` (saturated, qualified). Its transitions are start (IDLE→COUNT on a strobe with the line high), saturate (COUNT→HELD on the sixteenth strobe), drop (COUNT or HELD→IDLE on a low line) and clear (any state→IDLE). The interrupt machine has the states `IQ_QUIET`, `IQ_ARMED` and `IQ_RAISED`. Its transitions are arm (QUIET→ARMED when any channel is qualified), fire (ARMED→RAISED when none is) and clear (any state→QUIET, asynchronous).

Top module: `pulse_qual_irq`

## Requirements
- R1: A change on `sensor_in` reaches the channel logic through two synchronizer flops. A line driven high before clock edge 1, with a strobe on every cycle, raises `qualified` after edge 18 and not before.
- R2: A channel counter advances only on a cycle with `sample_tick` high and the synchronized line high. With no strobe it stays at zero however long the line is high.
- R3: A low synchronized line forces its counter to zero. A pulse that covers only 15 strobes leaves `qualified`, `chan_flag` and `irq` at 0.
- R4: `qualified[i]` (counter value 16, bit 4 of a 5-bit counter) goes high on the 16th counted strobe. It stays high while the line is high, whatever further strobes arrive.
- R5: `chan_flag[i]` goes high in the same cycle that `qualified[i]` rises. It stays high until the clear, including after the line drops.
- R6: `irq` rises one clock edge after the edge at which the last qualified counter returns to zero.
- R7: Once high, `irq` stays high until the clear, even when more qualified pulses come and go.
- R8: While `clr_n` is low, the counters and flags are zeroed at each clock edge. `irq` is driven low asynchronously as soon as `clr_n` falls.
- R9: When the clear is low at the edge where the last qualified counter falls to zero, no interrupt results after the clear is released.
- R10: When two channels' qualified pulses overlap, `irq` stays low until the later one has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| clr_n | input | 1 | Active-low processor clear of counters, flags and interrupt |
| sample_tick | input | 1 | One-cycle sampling strobe (slow rate) |
| sensor_in | input | NCH | Raw sensor pulse lines, active high |
| qualified | output | NCH | Counter top bit per channel (pulse long enough) |
| chan_flag | output | NCH | Sticky per-channel record of qualification |
| irq | output | 1 | Interrupt request, high once all qualified pulses ended |

## Verification
Two functions can meet in one cycle: the processor clear, and the fall of the combined qualified signal that would set the interrupt. The bench provokes this by dropping a saturated channel's line and timing `clr_n` to be low at exactly the edge where that counter returns to zero. It then releases the clear and checks that `irq` stays low for several cycles. The same meeting appears at random in a long constrained-random run with sporadic clears. There, every cycle is compared with a bench model in which the clear always takes precedence.

// File: rtl/pq_pkg.sv
package pq_pkg;

    // Per-channel qualifier states
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_HELD  = 2'd2
    } chan_state_t;

    // Interrupt generator states
    typedef enum logic [1:0] {
        IQ_QUIET  = 2'd0,
        IQ_ARMED  = 2'd1,
        IQ_RAISED = 2'd2
    } irq_state_t;

endpackage

// File: rtl/pq_sync.sv
module pq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pq_channel.sv
module pq_channel
    import pq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_n,
    input  logic tick,
    input  logic level,
    output logic top,
    output logic flag
);
    localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_VAL = {1'b0, {(CNT_W-1){1'b1}}};

    chan_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q, flag_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CH_IDLE;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        flag_d = flag_q;
        if (!clr_n) begin
            st_d   = CH_IDLE;
            cnt_d  = '0;
            flag_d = 1'b0;
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    cnt_d = '0;
                    if (level && tick) begin
                        st_d  = CH_COUNT;
                        cnt_d = ONE_VAL;
                    end
                end
                CH_COUNT: begin
                    if (!level) begin
                        st_d  = CH_IDLE;
                        cnt_d = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q + ONE_VAL;
                        if (cnt_q == LAST_VAL) begin
                            st_d   = CH_HELD;
                            flag_d = 1'b1;
                        end
                    end
                end
                CH_HELD: begin
                    if (!level) begin
                        st_d  = CH_IDLE;
                        cnt_d = '0;
                    end
                end
                default: begin
                    st_d  = CH_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        top  = cnt_q[CNT_W-1];
        flag = flag_q;
    end
endmodule

// File: rtl/pq_irq.sv
module pq_irq
    import pq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_n,
    input  logic [NCH-1:0] tops,
    output logic           irq
);
    irq_state_t st_q, st_d;
    logic       any_top;

    assign any_top = |tops;

    // State register, cleared asynchronously by either reset or clear
    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
        if (!rst_n)      st_q <= IQ_QUIET;
        else if (!clr_n) st_q <= IQ_QUIET;
        else             st_q <= st_d;
    end

    // Next-state logic: fire on the fall of the combined qualified bit
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IQ_QUIET:  if (any_top)  st_d = IQ_ARMED;
            IQ_ARMED:  if (!any_top) st_d = IQ_RAISED;
            IQ_RAISED: st_d = IQ_RAISED;
            default:   st_d = IQ_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        irq = (st_q == IQ_RAISED);
    end
endmodule

// File: rtl/pulse_qual_irq.sv
module pulse_qual_irq #(
    parameter int NCH         = 4,
    parameter int CNT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_n,
    input  logic           sample_tick,
    input  logic [NCH-1:0] sensor_in,
    output logic [NCH-1:0] qualified,
    output logic [NCH-1:0] chan_flag,
    output logic           irq
);
    logic [NCH-1:0] level_s;

    pq_sync #(
        .W      (NCH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sensor_in),
        .q     (level_s)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pq_channel #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_n (clr_n),
            .tick  (sample_tick),
            .level (level_s[i]),
            .top   (qualified[i]),
            .flag  (chan_flag[i])
        );
    end

    pq_irq #(
        .NCH (NCH)
    ) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_n (clr_n),
        .tops  (qualified),
        .irq   (irq)
    );
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clr_n,
    input logic           sample_tick,
    input logic [NCH-1:0] qualified,
    input logic [NCH-1:0] chan_flag,
    input logic           irq
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R2
        qual_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(qualified[i]) |-> $past(sample_tick));

        // R5
        flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_flag[i] && clr_n) |=> chan_flag[i]);

        // R5
        flag_with_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(chan_flag[i]) |-> qualified[i]);
    end

    // R8
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (chan_flag == '0 && qualified == '0));

    // R8
    irq_low_in_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> !irq);

    // R6
    irq_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(qualified == '0));

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && clr_n) |=> (irq || !clr_n));
endmodule

bind pulse_qual_irq pq_checker #(.NCH(NCH)) u_pq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_n       (clr_n),
    .sample_tick (sample_tick),
    .qualified   (qualified),
    .chan_flag   (chan_flag),
    .irq         (irq)
);

// File: tb/test_pulse_qual_irq.sv
`timescale 1ns/1ps
module test_pulse_qual_irq;
    localparam int NCH = 4;
    localparam int SAT = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           clr_n = 1'b1;
    logic           sample_tick = 1'b0;
    logic [NCH-1:0] sensor_in = '0;
    logic [NCH-1:0] qualified;
    logic [NCH-1:0] chan_flag;
    logic           irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pulse_qual_irq i_pulse_qual_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_n       (clr_n),
        .sample_tick (sample_tick),
        .sensor_in   (sensor_in),
        .qualified   (qualified),
        .chan_flag   (chan_flag),
        .irq         (irq)
    );

    // Reference model built from the requirements
    logic [NCH-1:0] m_s1 = '0, m_s2 = '0, m_flag = '0;
    int             m_cnt [NCH];
    int             m_ist = 0; // 0 quiet, 1 armed, 2 raised

    initial for (int i = 0; i < NCH; i++) m_cnt[i] = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_flag = '0; m_ist = 0;
            for (int i = 0; i < NCH; i++) m_cnt[i] = 0;
        end else begin
            bit any_old;
            any_old = 1'b0;
            for (int i = 0; i < NCH; i++) if (m_cnt[i] == SAT) any_old = 1'b1;
            for (int i = 0; i < NCH; i++) begin
                if (!clr_n) begin
                    m_cnt[i] = 0; m_flag[i] = 1'b0;
                end else if (!m_s2[i]) begin
                    m_cnt[i] = 0;
                end else if (sample_tick && m_cnt[i] < SAT) begin
                    m_cnt[i] = m_cnt[i] + 1;
                end
                if (clr_n && m_cnt[i] == SAT) m_flag[i] = 1'b1;
            end
            if (!clr_n)                      m_ist = 0;
            else if (m_ist == 0 && any_old)  m_ist = 1;
            else if (m_ist == 1 && !any_old) m_ist = 2;
            m_s2 = m_s1;
            m_s1 = sensor_in;
        end
    end

    function automatic logic [NCH-1:0] exp_qual();
        logic [NCH-1:0] r;
        for (int i = 0; i < NCH; i++) r[i] = (m_cnt[i] == SAT);
        return r;
    endfunction

    function automatic logic exp_irq();
        return (m_ist == 2) && clr_n;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk(qualified == exp_qual(), "R4 qualified vs model", qualified, exp_qual());
        chk(chan_flag == m_flag,     "R5 flags vs model",     chan_flag, m_flag);
        chk(irq == exp_irq(),        "R6 irq vs model",       irq, exp_irq());
    endtask

    // Drive one cycle at a negedge, then compare at the next negedge
    task automatic cyc(input logic t, input logic [NCH-1:0] s, input logic c);
        sample_tick = t;
        sensor_in   = s;
        clr_n       = c;
        @(negedge clk);
        compare_all();
    endtask

    task automatic cycn(input int n, input logic t, input logic [NCH-1:0] s, input logic c);
        for (int k = 0; k < n; k++) cyc(t, s, c);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cycn(3, 1'b0, 4'b0000, 1'b1);
        // R8 reset state
        chk(qualified == 0 && chan_flag == 0 && irq == 0, "R8 reset state",
            {qualified, chan_flag, irq}, 0);

        // R1 / R4: exact latency of qualification
        cycn(17, 1'b1, 4'b0001, 1'b1);
        chk(qualified[0] == 1'b0, "R1 not yet qualified after 17 edges", qualified[0], 0);
        cyc(1'b1, 4'b0001, 1'b1);
        chk(qualified[0] == 1'b1, "R1 qualified after 18 edges", qualified[0], 1);
        chk(chan_flag[0] == 1'b1, "R5 flag with qualification", chan_flag[0], 1);
        cycn(5, 1'b1, 4'b0001, 1'b1);
        chk(qualified[0] == 1'b1, "R4 saturated counter holds", qualified[0], 1);
        chk(irq == 1'b0, "R6 no irq while qualified", irq, 0);

        // R6: interrupt one edge after the counter zeroes
        cycn(3, 1'b0, 4'b0000, 1'b1);
        chk(qualified[0] == 1'b0 && irq == 1'b0, "R6 counter zero, irq not yet",
            {qualified[0], irq}, 0);
        cyc(1'b0, 4'b0000, 1'b1);
        chk(irq == 1'b1, "R6 irq after fall", irq, 1);
        chk(chan_flag[0] == 1'b1, "R5 flag survives line drop", chan_flag[0], 1);

        // R7: repeated pulse keeps irq high
        cycn(20, 1'b1, 4'b0001, 1'b1);
        cycn(5, 1'b0, 4'b0000, 1'b1);
        chk(irq == 1'b1, "R7 irq sticky across second pulse", irq, 1);

        // R8: synchronous clear of flags
        cyc(1'b0, 4'b0000, 1'b0);
        chk(chan_flag == 0 && irq == 0, "R8 clear", {chan_flag, irq}, 0);
        cycn(3, 1'b0, 4'b0000, 1'b1);

        // R3: 15-strobe pulse is rejected
        cycn(2, 1'b0, 4'b0010, 1'b1);
        cycn(15, 1'b1, 4'b0010, 1'b1);
        cycn(6, 1'b0, 4'b0000, 1'b1);
        chk(qualified == 0 && chan_flag == 0 && irq == 0, "R3 short pulse rejected",
            {qualified, chan_flag, irq}, 0);

        // R4: exactly 16 strobes qualifies
        cycn(2, 1'b0, 4'b0010, 1'b1);
        cycn(16, 1'b1, 4'b0010, 1'b1);
        chk(qualified[1] == 1'b1, "R4 sixteen strobes qualify", qualified[1], 1);
        cycn(6, 1'b0, 4'b0000, 1'b1);
        chk(chan_flag[1] == 1'b1 && irq == 1'b1, "R6 irq after 16-strobe pulse",
            {chan_flag[1], irq}, 3);
        cyc(1'b0, 4'b0000, 1'b0);
        cycn(2, 1'b0, 4'b0000, 1'b1);

        // R2: no strobe, no count
        cycn(40, 1'b0, 4'b0100, 1'b1);
        chk(qualified[2] == 1'b0, "R2 no strobes no count", qualified[2], 0);
        cycn(16, 1'b1, 4'b0100, 1'b1);
        chk(qualified[2] == 1'b1, "R2 counts once strobes arrive", qualified[2], 1);

        // R10: overlapping pulses on channels 2 and 3
        cycn(18, 1'b1, 4'b1100, 1'b1);
        chk(qualified[3:2] == 2'b11, "R10 both qualified", qualified[3:2], 3);
        cycn(6, 1'b0, 4'b1000, 1'b1);
        chk(qualified[2] == 1'b0 && irq == 1'b0, "R10 irq held while ch3 active",
            {qualified[2], irq}, 0);
        cycn(6, 1'b0, 4'b0000, 1'b1);
        chk(irq == 1'b1, "R10 irq after last channel ends", irq, 1);

        // R8: asynchronous drop of irq
        clr_n = 1'b0;
        #1;
        chk(irq == 1'b0, "R8 irq drops without clock", irq, 0);
        @(negedge clk);
        compare_all();
        cycn(2, 1'b0, 4'b0000, 1'b1);

        // R9: clear coincides with the fall of the combined qualified bit
        cycn(18, 1'b1, 4'b0001, 1'b1);
        cycn(2, 1'b0, 4'b0000, 1'b1);
        chk(qualified[0] == 1'b1, "R9 still qualified before fall edge", qualified[0], 1);
        cyc(1'b0, 4'b0000, 1'b0);
        cycn(8, 1'b0, 4'b0000, 1'b1);
        chk(irq == 1'b0 && chan_flag == 0, "R9 clear wins over fall",
            {irq, chan_flag}, 0);

        // Constrained random phase
        begin
            logic [NCH-1:0] s;
            int clr_left;
            s = '0;
            clr_left = 0;
            for (int k = 0; k < 6000; k++) begin
                for (int i = 0; i < NCH; i++) if ($urandom % 40 == 0) s[i] = ~s[i];
                if (clr_left == 0 && $urandom % 300 == 0) clr_left = 1 + $urandom % 3;
                cyc(($urandom % 3) == 0, s, clr_left == 0);
                if (clr_left > 0) clr_left--;
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule